// File: doc/BRIEF.md
# Serial Port Control and Error-Flag Register

This block is the 32-bit control word for one port of a serial packet link controller. Software writes it through a plain register interface. The block drives the port's mode and enable controls from the stored fields. It also accepts event pulses from the link hardware.

The word combines several kinds of bit:

- ordinary read/write settings: the flow-control direction, software error recovery, debug mode, error reporting enable, retry threshold and interrupt enable;
- a transfer-mode field that refuses reserved codes;
- a write-only reinitialization strobe;
- a debug-packet send request that clears itself once the hardware reports the packet as sent;
- two sticky error flags that software clears by writing 1.

The illegal-transfer flag has a second clear path, a clear-all strobe that arrives from the port's error-detect register.

When software recovery is selected, the block does not pass recovery requests to the hardware sequencer. Instead it holds the transmitter in a wait state until software updates the local acknowledge-ID status, which reaches this block as an input pulse. The interrupt output combines each error flag with its own enable.

Reads are combinational from the stored state. A write takes effect at the rising clock edge on which `reg_wr` is high. The register interface has no handshake: every write is accepted in its cycle.

Top module: `pcsr_port_ctl`

## Requirements
- R1: After reset the word reads 0x0100_0000: the transfer mode is 01 and every other field is 0. All outputs are low except `xfer_mode`, which is 01.
- R2: These bits are stored from a write and read back, each driving its output: bit 30 (`tx_flow_en`; 0 means receive-side flow control), bit 29 (`sw_recovery`), bit 23 (`debug_mode`), bit 21 (`ill_rpt_en`), bits 15:8 (`retry_thr`) and bit 7 (`irq_en`). Bits 31, 28:27, 19:16 and 5:0 always read 0 and ignore writes.
- R3: Writing 1 to bit 26 makes `reinit_pulse` high for exactly the next cycle. Bit 26 always reads 0.
- R4: Bits 25:24 (`xfer_mode`) accept a write of 00 or 01. A write whose bit 25 is 1 leaves the field unchanged.
- R5: While bit 23 is already 1, writing 1 to bit 22 sets the send request (`dbg_send_req`). Outside debug mode such a write has no effect. The request clears on the cycle after `dbg_pkt_sent` is seen high.
- R6: While bit 22 is set, writes to bit 22 are ignored, and the request stays set until `dbg_pkt_sent`.
- R7: Bit 20 (illegal-transfer flag) is set by any of `ill_tt_rsvd`, `ill_maint_rsvd` or `ill_destid_miss`. It stays set until software writes 1 to bit 20 or `err_det_clr_all` is high. A set event in the same cycle as a clear leaves it set.
- R8: Bit 6 (interrupt error flag) is set by `irq_err_evt` and cleared by writing 1 to bit 6. A set event in the same cycle as the clear wins.
- R9: `irq` is high exactly when both bits 20 and 21 are 1, or both bits 6 and 7 are 1.
- R10: `hw_recov_start` equals `recov_needed` while bit 29 is 0, and is 0 while bit 29 is 1. When `recov_needed` is high while bit 29 is 1, `tx_wait` goes high on the next cycle. It then stays high until the cycle after `ackid_sw_wr` is seen high; if a new request arrives in that same cycle, the request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current value of the control word |
| dbg_pkt_sent | input | 1 | Hardware reports the debug packet as sent |
| ill_tt_rsvd | input | 1 | Received a reserved transport-type field |
| ill_maint_rsvd | input | 1 | Received a reserved maintenance transaction field |
| ill_destid_miss | input | 1 | Destination ID missing from the lookup table |
| err_det_clr_all | input | 1 | Clear-all strobe from the error-detect register |
| irq_err_evt | input | 1 | Sets the interrupt error flag |
| recov_needed | input | 1 | Link requests an error recovery sequence |
| ackid_sw_wr | input | 1 | Software wrote the local acknowledge-ID status |
| tx_flow_en | output | 1 | Transmit flow control enabled |
| sw_recovery | output | 1 | Software-controlled recovery selected |
| xfer_mode | output | 2 | Transfer mode |
| debug_mode | output | 1 | Debug mode selected |
| dbg_send_req | output | 1 | Pending debug packet request |
| ill_rpt_en | output | 1 | Illegal-transfer reporting enabled |
| retry_thr | output | 8 | Retry threshold |
| irq_en | output | 1 | Interrupt error enable |
| reinit_pulse | output | 1 | One-cycle reinitialization request |
| hw_recov_start | output | 1 | Start of a hardware recovery sequence |
| tx_wait | output | 1 | Transmitter waiting for software recovery |
| irq | output | 1 | Error interrupt request |

## Verification
Some properties are checked on every cycle by assertions:

- a sticky flag never drops without a clear, and every set event is captured;
- the debug request holds until the sent report, and can only rise in debug mode;
- the reinit pulse follows a write of bit 26;
- the stored mode never holds a reserved code;
- the interrupt never fires without an enable;
- the transmitter wait holds until the software release.

The bench's scenarios cover what the assertions do not:

- exact readback of the whole word after random write sequences;
- that a reserved-mode write or an out-of-debug-mode send write leaves the state as it was;
- the full truth of the interrupt combination;
- the priority of a set over a simultaneous write-1 or clear-all.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned THR_W    = 8;

  localparam int unsigned B_TXFLOW = 30;
  localparam int unsigned B_SWREC  = 29;
  localparam int unsigned B_REINIT = 26;
  localparam int unsigned B_MODE_H = 25;
  localparam int unsigned B_MODE_L = 24;
  localparam int unsigned B_DEBUG  = 23;
  localparam int unsigned B_DBGSND = 22;
  localparam int unsigned B_ILLEN  = 21;
  localparam int unsigned B_ILLERR = 20;
  localparam int unsigned B_THR_L  = 8;
  localparam int unsigned B_IRQEN  = 7;
  localparam int unsigned B_IRQERR = 6;

  localparam logic [1:0] MODE_RST = 2'b01;

  typedef struct packed {
    logic             tx_flow;
    logic             sw_rec;
    logic [1:0]       mode;
    logic             debug;
    logic             ill_en;
    logic [THR_W-1:0] thr;
    logic             irq_en;
  } cfg_t;
endpackage

// File: rtl/pcsr_cfg_fields.sv
module pcsr_cfg_fields
  import pcsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [WORD_W-1:0] wdata,
  output cfg_t       cfg
);
  localparam int unsigned THR_H = B_THR_L + THR_W - 1;

  cfg_t cfg_q;
  logic mode_ok;

  // only bit 25 clear marks an accepted code (00 or 01)
  assign mode_ok = ~wdata[B_MODE_H];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q        <= '0;
      cfg_q.mode   <= MODE_RST;
    end else if (wr) begin
      cfg_q.tx_flow <= wdata[B_TXFLOW];
      cfg_q.sw_rec  <= wdata[B_SWREC];
      cfg_q.debug   <= wdata[B_DEBUG];
      cfg_q.ill_en  <= wdata[B_ILLEN];
      cfg_q.thr     <= wdata[THR_H:B_THR_L];
      cfg_q.irq_en  <= wdata[B_IRQEN];
      if (mode_ok) cfg_q.mode <= wdata[B_MODE_H:B_MODE_L];
    end
  end

  assign cfg = cfg_q;

  // R4: a reserved code never reaches the stored field
  a_r4_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.mode[1]);
  // R4: a rejected write keeps the previous mode
  a_r4_mode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[B_MODE_H]) |=> $stable(cfg_q.mode));
endmodule

// File: rtl/pcsr_sticky_flag.sv
module pcsr_sticky_flag #(
  parameter int unsigned NSRC = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_src,
  input  logic            clr,
  output logic            flag
);
  logic flag_q;
  logic any_set;

  assign any_set = |set_src;

  always_ff @(posedge clk) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (any_set) flag_q <= 1'b1;
    else if (clr)     flag_q <= 1'b0;
  end

  assign flag = flag_q;

  // R7/R8: a flag only drops through a clear
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  // R7/R8: any set event is captured, even against a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    any_set |=> flag_q);
endmodule

// File: rtl/pcsr_dbg_req.sv
module pcsr_dbg_req (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_set,
  input  logic dbg_mode,
  input  logic pkt_sent,
  output logic req
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      req_q <= 1'b0;
    else if (req_q)                  req_q <= ~pkt_sent;
    else if (wr_set && dbg_mode)     req_q <= 1'b1;
  end

  assign req = req_q;

  // R6: pending request survives any write until the sent report
  a_r6_hold_until_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !pkt_sent) |=> req_q);
  // R5: request rises only out of debug mode writes
  a_r5_needs_debug: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> $past(dbg_mode && wr_set));
  // R5: the sent report retires the request
  a_r5_sent_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && pkt_sent) |=> !req_q);
endmodule

// File: rtl/pcsr_recovery.sv
module pcsr_recovery (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_reinit,
  input  logic sw_rec,
  input  logic recov_needed,
  input  logic ackid_sw_wr,
  output logic reinit_pulse,
  output logic hw_recov_start,
  output logic tx_wait
);
  logic reinit_q;
  logic wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reinit_q <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      reinit_q <= wr_reinit;
      if (recov_needed && sw_rec) wait_q <= 1'b1;
      else if (ackid_sw_wr)       wait_q <= 1'b0;
    end
  end

  assign reinit_pulse   = reinit_q;
  assign hw_recov_start = recov_needed & ~sw_rec;
  assign tx_wait        = wait_q;

  // R3: every reinit write yields the pulse, and no pulse without one
  a_r3_reinit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reinit |=> reinit_q);
  a_r3_reinit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reinit_q) |-> $past(wr_reinit));
  // R10: the wait holds until software releases it
  a_r10_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q && !ackid_sw_wr) |=> wait_q);
  a_r10_wait_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wait_q) |-> $past(sw_rec && recov_needed));
endmodule

// File: rtl/pcsr_port_ctl.sv
module pcsr_port_ctl
  import pcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              dbg_pkt_sent,
  input  logic              ill_tt_rsvd,
  input  logic              ill_maint_rsvd,
  input  logic              ill_destid_miss,
  input  logic              err_det_clr_all,
  input  logic              irq_err_evt,
  input  logic              recov_needed,
  input  logic              ackid_sw_wr,
  output logic              tx_flow_en,
  output logic              sw_recovery,
  output logic [1:0]        xfer_mode,
  output logic              debug_mode,
  output logic              dbg_send_req,
  output logic              ill_rpt_en,
  output logic [THR_W-1:0]  retry_thr,
  output logic              irq_en,
  output logic              reinit_pulse,
  output logic              hw_recov_start,
  output logic              tx_wait,
  output logic              irq
);
  localparam int unsigned NILL = 3;

  cfg_t            cfg;
  logic            ill_flag;
  logic            irq_flag;
  logic [NILL-1:0] ill_src;
  logic            ill_clr;
  logic            irq_clr;

  pcsr_cfg_fields u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .cfg   (cfg)
  );

  assign ill_src = {ill_destid_miss, ill_maint_rsvd, ill_tt_rsvd};
  assign ill_clr = (reg_wr & reg_wdata[B_ILLERR]) | err_det_clr_all;
  assign irq_clr = reg_wr & reg_wdata[B_IRQERR];

  pcsr_sticky_flag #(.NSRC(NILL)) u_ill (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_src (ill_src),
    .clr     (ill_clr),
    .flag    (ill_flag)
  );

  pcsr_sticky_flag #(.NSRC(1)) u_irqerr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_src (irq_err_evt),
    .clr     (irq_clr),
    .flag    (irq_flag)
  );

  pcsr_dbg_req u_dbg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_set   (reg_wr & reg_wdata[B_DBGSND]),
    .dbg_mode (cfg.debug),
    .pkt_sent (dbg_pkt_sent),
    .req      (dbg_send_req)
  );

  pcsr_recovery u_rec (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_reinit      (reg_wr & reg_wdata[B_REINIT]),
    .sw_rec         (cfg.sw_rec),
    .recov_needed   (recov_needed),
    .ackid_sw_wr    (ackid_sw_wr),
    .reinit_pulse   (reinit_pulse),
    .hw_recov_start (hw_recov_start),
    .tx_wait        (tx_wait)
  );

  always_comb begin
    reg_rdata                                 = '0;
    reg_rdata[B_TXFLOW]                       = cfg.tx_flow;
    reg_rdata[B_SWREC]                        = cfg.sw_rec;
    reg_rdata[B_MODE_H:B_MODE_L]              = cfg.mode;
    reg_rdata[B_DEBUG]                        = cfg.debug;
    reg_rdata[B_DBGSND]                       = dbg_send_req;
    reg_rdata[B_ILLEN]                        = cfg.ill_en;
    reg_rdata[B_ILLERR]                       = ill_flag;
    reg_rdata[B_THR_L+THR_W-1:B_THR_L]        = cfg.thr;
    reg_rdata[B_IRQEN]                        = cfg.irq_en;
    reg_rdata[B_IRQERR]                       = irq_flag;
  end

  assign tx_flow_en  = cfg.tx_flow;
  assign sw_recovery = cfg.sw_rec;
  assign xfer_mode   = cfg.mode;
  assign debug_mode  = cfg.debug;
  assign ill_rpt_en  = cfg.ill_en;
  assign retry_thr   = cfg.thr;
  assign irq_en      = cfg.irq_en;
  assign irq         = (ill_flag & cfg.ill_en) | (irq_flag & cfg.irq_en);

  // R9: no interrupt without an enabled flag
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((ill_rpt_en && reg_rdata[B_ILLERR]) || (irq_en && reg_rdata[B_IRQERR])));
  // R3: the write-only bit never reads back
  a_r3_reinit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[B_REINIT]);
endmodule

// File: tb/pcsr_port_ctl_tb_top.sv
module pcsr_port_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic dbg_pkt_sent = 0, ill_tt_rsvd = 0, ill_maint_rsvd = 0, ill_destid_miss = 0;
  logic err_det_clr_all = 0, irq_err_evt = 0, recov_needed = 0, ackid_sw_wr = 0;
  logic tx_flow_en, sw_recovery, debug_mode, dbg_send_req, ill_rpt_en, irq_en;
  logic reinit_pulse, hw_recov_start, tx_wait, irq;
  logic [1:0] xfer_mode;
  logic [7:0] retry_thr;

  pcsr_port_ctl dut_i (.*);

  int n_chk = 0, n_fail = 0;

  // expected state
  logic m_flow, m_sw, m_dbg, m_req, m_ren, m_ill, m_ien, m_f6, m_reinit, m_wait;
  logic [1:0] m_mode;
  logic [7:0] m_thr;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word();
    return {1'b0, m_flow, m_sw, 2'b00, 1'b0, m_mode, m_dbg, m_req, m_ren, m_ill,
            4'h0, m_thr, m_ien, m_f6, 6'h00};
  endfunction

  function automatic logic exp_irq();
    return (m_ill & m_ren) | (m_f6 & m_ien);
  endfunction

  task automatic model_reset();
    {m_flow, m_sw, m_dbg, m_req, m_ren, m_ill, m_ien, m_f6, m_reinit, m_wait} = '0;
    m_mode = 2'b01;
    m_thr  = 8'h00;
  endtask

  // next-state from the inputs currently driven
  task automatic model_step();
    logic sw_old, dbg_old;
    sw_old = m_sw;
    dbg_old = m_dbg;
    m_reinit = reg_wr & reg_wdata[26];
    if (m_req) m_req = ~dbg_pkt_sent;
    else if (reg_wr && reg_wdata[22] && dbg_old) m_req = 1'b1;
    if (ill_tt_rsvd | ill_maint_rsvd | ill_destid_miss) m_ill = 1'b1;
    else if ((reg_wr & reg_wdata[20]) | err_det_clr_all) m_ill = 1'b0;
    if (irq_err_evt) m_f6 = 1'b1;
    else if (reg_wr & reg_wdata[6]) m_f6 = 1'b0;
    if (recov_needed & sw_old) m_wait = 1'b1;
    else if (ackid_sw_wr) m_wait = 1'b0;
    if (reg_wr) begin
      m_flow = reg_wdata[30]; m_sw = reg_wdata[29]; m_dbg = reg_wdata[23];
      m_ren = reg_wdata[21]; m_thr = reg_wdata[15:8]; m_ien = reg_wdata[7];
      if (!reg_wdata[25]) m_mode = reg_wdata[25:24];
    end
  endtask

  task automatic check_state();
    chk("R2 R4 R5 R7 R8 rdata word", reg_rdata, exp_word());
    chk("R2 field outputs", {tx_flow_en, sw_recovery, debug_mode, ill_rpt_en, irq_en, retry_thr},
        {m_flow, m_sw, m_dbg, m_ren, m_ien, m_thr});
    chk("R4 xfer_mode", xfer_mode, m_mode);
    chk("R5 R6 dbg_send_req", dbg_send_req, m_req);
    chk("R3 reinit_pulse", reinit_pulse, m_reinit);
    chk("R9 irq", irq, exp_irq());
    chk("R10 tx_wait", tx_wait, m_wait);
  endtask

  // one cycle: drive at negedge, check combinational, advance
  task automatic cycle();
    #1;
    chk("R10 hw_recov_start", hw_recov_start, recov_needed & ~m_sw);
    model_step();
    @(negedge clk);
    reg_wr = 0; dbg_pkt_sent = 0; ill_tt_rsvd = 0; ill_maint_rsvd = 0; ill_destid_miss = 0;
    err_det_clr_all = 0; irq_err_evt = 0; recov_needed = 0; ackid_sw_wr = 0;
    check_state();
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1; reg_wdata = d;
    cycle();
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset value
    chk("R1 reset word", reg_rdata, 32'h0100_0000);
    chk("R1 reset outputs", {reinit_pulse, tx_wait, irq, dbg_send_req}, 4'b0000);
    // R2: reserved bits ignore writes
    wr(32'hFFFF_FFFF & ~32'h0400_0000 & ~32'h0200_0000 & ~32'h0040_0000);
    wr(32'h0000_0000);
    // R4: reserved mode code ignored
    wr(32'h0000_0000);
    wr(32'h0200_0000);
    chk("R4 mode after reserved write", xfer_mode, 2'b00);
    wr(32'h0300_0000);
    chk("R4 mode after 11 write", xfer_mode, 2'b00);
    // R5: send request outside debug mode has no effect
    wr(32'h0040_0000);
    chk("R5 no request outside debug", dbg_send_req, 1'b0);
    wr(32'h0080_0000);
    wr(32'h00C0_0000);
    chk("R5 request set in debug", dbg_send_req, 1'b1);
    // R6: write 0 ignored while pending
    wr(32'h0080_0000);
    chk("R6 request held", dbg_send_req, 1'b1);
    dbg_pkt_sent = 1; cycle();
    chk("R5 request cleared by sent", dbg_send_req, 1'b0);
    // R3: reinit pulse and readback
    wr(32'h0400_0000);
    chk("R3 pulse high", reinit_pulse, 1'b1);
    chk("R3 bit reads 0", reg_rdata[26], 1'b0);
    cycle();
    chk("R3 pulse one cycle", reinit_pulse, 1'b0);
    // R7: set wins over write-1 clear; clear-all path
    ill_destid_miss = 1; reg_wr = 1; reg_wdata = 32'h0030_0000; cycle();
    chk("R7 set wins", reg_rdata[20], 1'b1);
    chk("R9 irq with enable", irq, 1'b1);
    err_det_clr_all = 1; cycle();
    chk("R7 clear-all", reg_rdata[20], 1'b0);
    // R8: set wins over write-1 clear
    irq_err_evt = 1; reg_wr = 1; reg_wdata = 32'h0000_0040; cycle();
    chk("R8 set wins", reg_rdata[6], 1'b1);
    wr(32'h0000_0040);
    chk("R8 write-1 clears", reg_rdata[6], 1'b0);
    // R10: software recovery wait
    wr(32'h2100_0000);
    recov_needed = 1; cycle();
    chk("R10 wait entered", tx_wait, 1'b1);
    cycle();
    chk("R10 wait held", tx_wait, 1'b1);
    ackid_sw_wr = 1; cycle();
    chk("R10 wait released", tx_wait, 1'b0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      reg_wr = ($urandom_range(0, 99) < 30);
      reg_wdata = $urandom();
      if ($urandom_range(0, 3) != 0) reg_wdata[20] = 1'b0;
      if ($urandom_range(0, 3) != 0) reg_wdata[6] = 1'b0;
      dbg_pkt_sent    = ($urandom_range(0, 99) < 20);
      ill_tt_rsvd     = ($urandom_range(0, 99) < 3);
      ill_maint_rsvd  = ($urandom_range(0, 99) < 3);
      ill_destid_miss = ($urandom_range(0, 99) < 3);
      err_det_clr_all = ($urandom_range(0, 99) < 4);
      irq_err_evt     = ($urandom_range(0, 99) < 5);
      recov_needed    = ($urandom_range(0, 99) < 10);
      ackid_sw_wr     = ($urandom_range(0, 99) < 10);
      cycle();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule